// File: doc/BRIEF.md
# Ordered Atomic Load/Store Decode and Alignment Check

This block examines one 32-bit instruction word from the atomic major opcode space. It recognises the standalone load-acquire and store-release forms, validates their reserved-encoding rules and reports the operation's direction, access size, effective ordering and the data byte lanes it uses. For a legal operation it also checks the effective address. A misaligned access is never split into smaller accesses. If all of its bytes fall inside one misaligned-atomicity granule, it proceeds without an exception. Otherwise it is reported either as address-misaligned or, when the region forbids emulation, as an access fault.

The block sits beside the load/store unit's issue logic. The unit gives it the instruction, the computed address and a per-access flag saying whether emulation of the access is forbidden. The unit then uses the ordering outputs to hold younger operations behind an acquire, or to drain older operations ahead of a release. It raises the reported exception or illegal-instruction trap itself. Parameters choose the register width (32 or 64), the granule size as a power of two, and whether the results pass through one output register stage.

Top module: `acqrel_op_check`

## Requirements
- R1: The block recognises an instruction only when bits [6:0] equal 7'b0101111 and bits [31:27] equal 5'b00110 (load) or 5'b00111 (store). `o_match` is then 1 and `o_is_store` equals bit 27. For any other word, every output is 0.
- R2: A recognised load is illegal (`o_illegal`=1) when its acquire bit (bit 26) is 0 or its rs2 field (bits [24:20]) is nonzero.
- R3: A recognised store is illegal when its release bit (bit 25) is 0 or its rd field (bits [11:7]) is nonzero.
- R4: For a legal operation, `o_size` equals funct3[1:0] (bits [13:12]): 0 = byte, 1 = half, 2 = word, 3 = double. A recognised word is illegal when funct3 bit 2 (bit 14) is 1, and also when funct3 is 3 with XLEN = 32.
- R5: For a legal load, `o_acq` is 1 and `o_rel` equals bit 25. For a legal store, `o_rel` is 1 and `o_acq` equals bit 26.
- R6: For a legal operation, `o_mask` has exactly its lowest 2^`o_size` bits set.
- R7: A legal access whose address is a multiple of its size gives `o_exc` = 0.
- R8: A legal misaligned access whose first and last byte addresses differ in any bit at or above GRAN_LOG2 reports address-misaligned when `i_no_emul`=0. The code is 4 for a load and 6 for a store. The last byte address wraps modulo 2^XLEN.
- R9: The same crossing access with `i_no_emul`=1 reports an access fault. The code is 5 for a load and 7 for a store.
- R10: A legal misaligned access whose bytes all lie in one 2^GRAN_LOG2-byte granule gives `o_exc` = 0.
- R11: `o_valid` = `o_match` AND NOT `o_illegal`. While `o_valid` is 0, `o_size`, `o_acq`, `o_rel`, `o_mask` and `o_exc` are 0.
- R12: With REG_OUT = 1, the outputs show the inputs sampled at the previous rising clock edge, and an active-low `rst_n` clears every output to 0. With REG_OUT = 0, the outputs follow the inputs with no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| i_instr | input | 32 | Instruction word under test |
| i_addr | input | XLEN | Effective byte address of the access |
| i_no_emul | input | 1 | 1 when the region forbids emulating a misaligned access |
| o_match | output | 1 | Word is a load-acquire or store-release form |
| o_valid | output | 1 | Recognised and legal |
| o_illegal | output | 1 | Recognised but a reserved encoding |
| o_is_store | output | 1 | Recognised form is the store |
| o_size | output | 2 | log2 of the access size in bytes |
| o_acq | output | 1 | Effective acquire ordering |
| o_rel | output | 1 | Effective release ordering |
| o_mask | output | XLEN/8 | Data byte lanes used, low-aligned |
| o_exc | output | 4 | Exception code: 0 none, 4/5 load misaligned/fault, 6/7 store misaligned/fault |

## Verification
The only state is the output register. A corrupted or stale entry therefore shows at the ports in the cycle after the offending input, and lasts only until the next edge: a wrong direction, a missing mandatory ordering bit, a mask that does not match the size, or an exception code of the wrong direction. Because each input is checked on the cycle after it is applied, any stuck or mis-sliced field is reported one cycle after the stimulus that exposes it. Address cases at granule edges and at the top of the address space expose errors in the crossing comparison.

// File: rtl/acqrel_pkg.sv
package acqrel_pkg;

   localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
   localparam logic [4:0] F5_LD_ACQ  = 5'b00110;
   localparam logic [4:0] F5_ST_REL  = 5'b00111;

   typedef enum logic [3:0] {
      EXC_NONE   = 4'd0,
      EXC_LD_MIS = 4'd4,
      EXC_LD_FLT = 4'd5,
      EXC_ST_MIS = 4'd6,
      EXC_ST_FLT = 4'd7
   } exc_e;

   typedef struct packed {
      logic       match;
      logic       valid;
      logic       illegal;
      logic       is_store;
      logic [1:0] size;
      logic       acq;
      logic       rel;
   } dec_t;

endpackage

// File: rtl/acqrel_dec.sv
module acqrel_dec
   import acqrel_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [6:0] f_opc;
   logic [4:0] f_rd;
   logic [2:0] f_f3;
   logic [4:0] f_rs2;
   logic       f_aq;
   logic       f_rl;
   logic [4:0] f_f5;
   logic       unused_rs1;
   logic       dbl_ok;

   assign f_opc      = instr[6:0];
   assign f_rd       = instr[11:7];
   assign f_f3       = instr[14:12];
   assign f_rs2      = instr[24:20];
   assign f_rl       = instr[25];
   assign f_aq       = instr[26];
   assign f_f5       = instr[31:27];
   assign unused_rs1 = ^instr[19:15];

   generate
      if (XLEN == 64) begin : g_wide
         assign dbl_ok = 1'b1;
      end else begin : g_narrow
         assign dbl_ok = 1'b0;
      end
   endgenerate

   logic hit_ld, hit_st, size_bad, ld_bad, st_bad;

   always_comb begin
      hit_ld   = (f_opc == OPC_ATOMIC) && (f_f5 == F5_LD_ACQ);
      hit_st   = (f_opc == OPC_ATOMIC) && (f_f5 == F5_ST_REL);
      size_bad = f_f3[2] | ((f_f3[1:0] == 2'b11) & ~dbl_ok);
      ld_bad   = ~f_aq | (f_rs2 != 5'd0);
      st_bad   = ~f_rl | (f_rd != 5'd0);

      dec          = '0;
      dec.match    = hit_ld | hit_st;
      dec.is_store = hit_st;
      dec.illegal  = (hit_ld & (ld_bad | size_bad)) | (hit_st & (st_bad | size_bad));
      dec.valid    = dec.match & ~dec.illegal;
      if (dec.valid) begin
         dec.size = f_f3[1:0];
         dec.acq  = hit_ld | f_aq;
         dec.rel  = hit_st | f_rl;
      end
   end

endmodule

// File: rtl/acqrel_align.sv
module acqrel_align
   import acqrel_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int GRAN_LOG2 = 4,
   localparam int MW       = XLEN / 8
) (
   input  logic [XLEN-1:0] addr,
   input  logic [1:0]      size,
   input  logic            is_store,
   input  logic            no_emul,
   input  logic            en,
   output logic [3:0]      exc,
   output logic [MW-1:0]   lanes
);

   logic [XLEN-1:0] low_bits;
   logic [XLEN-1:0] last_byte;
   logic            off_grid;
   logic            same_gran;

   always_comb begin
      low_bits  = XLEN'((4'd1 << size) - 4'd1);
      last_byte = addr + low_bits;
      off_grid  = |(addr & low_bits);
      same_gran = (addr[XLEN-1:GRAN_LOG2] == last_byte[XLEN-1:GRAN_LOG2]);
   end

   always_comb begin
      exc = EXC_NONE;
      if (en && off_grid && !same_gran) begin
         if (is_store) exc = no_emul ? EXC_ST_FLT : EXC_ST_MIS;
         else          exc = no_emul ? EXC_LD_FLT : EXC_LD_MIS;
      end
   end

   always_comb begin
      for (int i = 0; i < MW; i++) begin
         lanes[i] = en && (i < (32'd1 << size));
      end
   end

endmodule

// File: rtl/acqrel_pipe.sv
module acqrel_pipe #(
   parameter int W   = 8,
   parameter int REG = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (REG != 0) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_wire
         logic unused_ck;
         assign unused_ck = clk ^ rst_n;
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/acqrel_op_check.sv
module acqrel_op_check
   import acqrel_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int GRAN_LOG2 = 4,
   parameter int REG_OUT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       i_instr,
   input  logic [XLEN-1:0]   i_addr,
   input  logic              i_no_emul,
   output logic              o_match,
   output logic              o_valid,
   output logic              o_illegal,
   output logic              o_is_store,
   output logic [1:0]        o_size,
   output logic              o_acq,
   output logic              o_rel,
   output logic [XLEN/8-1:0] o_mask,
   output logic [3:0]        o_exc
);

   localparam int MW = XLEN / 8;
   localparam int PW = $bits(dec_t) + MW + 4;

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("acqrel_op_check: XLEN must be 32 or 64");
      end
      if (GRAN_LOG2 < 0 || GRAN_LOG2 >= XLEN) begin : g_bad_gran
         $error("acqrel_op_check: GRAN_LOG2 out of range");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("acqrel_op_check: REG_OUT must be 0 or 1");
      end
   endgenerate

   dec_t          dec;
   logic [3:0]    exc_c;
   logic [MW-1:0] lanes_c;
   logic [PW-1:0] pipe_d, pipe_q;

   acqrel_dec #(.XLEN(XLEN)) u_dec (
      .instr (i_instr),
      .dec   (dec)
   );

   acqrel_align #(.XLEN(XLEN), .GRAN_LOG2(GRAN_LOG2)) u_align (
      .addr     (i_addr),
      .size     (dec.size),
      .is_store (dec.is_store),
      .no_emul  (i_no_emul),
      .en       (dec.valid),
      .exc      (exc_c),
      .lanes    (lanes_c)
   );

   assign pipe_d = {dec, lanes_c, exc_c};

   acqrel_pipe #(.W(PW), .REG(REG_OUT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pipe_d),
      .q     (pipe_q)
   );

   dec_t dec_q;
   assign {dec_q, o_mask, o_exc} = pipe_q;
   assign o_match    = dec_q.match;
   assign o_valid    = dec_q.valid;
   assign o_illegal  = dec_q.illegal;
   assign o_is_store = dec_q.is_store;
   assign o_size     = dec_q.size;
   assign o_acq      = dec_q.acq;
   assign o_rel      = dec_q.rel;

endmodule

// File: rtl/acqrel_op_check_sva.sv
module acqrel_op_check_sva #(
   parameter int XLEN    = 64,
   parameter int REG_OUT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       i_instr,
   input logic [XLEN-1:0]   i_addr,
   input logic              o_match,
   input logic              o_valid,
   input logic              o_illegal,
   input logic              o_is_store,
   input logic [1:0]        o_size,
   input logic              o_acq,
   input logic              o_rel,
   input logic [XLEN/8-1:0] o_mask,
   input logic [3:0]        o_exc
);

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   function automatic logic [XLEN-1:0] low_of(input logic [1:0] s);
      return XLEN'((4'd1 << s) - 4'd1);
   endfunction

   a_r11_valid_legal: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> (o_match && !o_illegal));

   a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      o_illegal |-> (!o_valid && o_exc == 4'd0 && o_mask == '0 && !o_acq && !o_rel));

   a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !o_match |-> (!o_illegal && !o_is_store && !o_valid));

   a_r5_load_acq: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_is_store) |-> o_acq);

   a_r5_store_rel: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_is_store) |-> o_rel);

   a_r6_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |-> ($countones(o_mask) == (1 << o_size)));

   a_r8_exc_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (o_exc != 4'd0) |-> (o_valid && o_exc[3:2] == 2'b01 && o_exc[1] == o_is_store));

   generate
      if (REG_OUT != 0) begin : g_reg
         a_r7_aligned_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && o_valid && (($past(i_addr) & low_of(o_size)) == '0)) |-> (o_exc == 4'd0));
         a_r1_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(i_instr[6:0]) != 7'b0101111) |-> !o_match);
      end else begin : g_comb
         logic unused_pr;
         assign unused_pr = primed;
         a_r7_aligned_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (o_valid && ((i_addr & low_of(o_size)) == '0)) |-> (o_exc == 4'd0));
         a_r1_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (i_instr[6:0] != 7'b0101111) |-> !o_match);
      end
   endgenerate

endmodule

bind acqrel_op_check acqrel_op_check_sva #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .i_instr    (i_instr),
   .i_addr     (i_addr),
   .o_match    (o_match),
   .o_valid    (o_valid),
   .o_illegal  (o_illegal),
   .o_is_store (o_is_store),
   .o_size     (o_size),
   .o_acq      (o_acq),
   .o_rel      (o_rel),
   .o_mask     (o_mask),
   .o_exc      (o_exc)
);

// File: tb/test_acqrel_op_check.sv
module test_acqrel_op_check;

   localparam int TB_XLEN = 64;
   localparam int TB_GL   = 4;

   logic        clk;
   logic        rst_n;
   logic [31:0] i_instr;
   logic [63:0] i_addr;
   logic        i_no_emul;
   logic        o_match, o_valid, o_illegal, o_is_store, o_acq, o_rel;
   logic [1:0]  o_size;
   logic [7:0]  o_mask;
   logic [3:0]  o_exc;

   int checks = 0;
   int errors = 0;

   acqrel_op_check #(.XLEN(TB_XLEN), .GRAN_LOG2(TB_GL), .REG_OUT(1)) i_acqrel_op_check (
      .clk(clk), .rst_n(rst_n), .i_instr(i_instr), .i_addr(i_addr), .i_no_emul(i_no_emul),
      .o_match(o_match), .o_valid(o_valid), .o_illegal(o_illegal), .o_is_store(o_is_store),
      .o_size(o_size), .o_acq(o_acq), .o_rel(o_rel), .o_mask(o_mask), .o_exc(o_exc)
   );

   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq, input logic rl,
                                       input logic [4:0] rs2, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] opc);
      return {f5, aq, rl, rs2, rs1, f3, rd, opc};
   endfunction

   // layout: match valid illegal store size[2] acq rel mask[8] exc[4]
   function automatic logic [19:0] model(input logic [31:0] ins, input logic [63:0] ad, input logic ne);
      logic m, st, ill, v, a, r;
      logic [1:0]  sz;
      logic [7:0]  mk;
      logic [3:0]  ex;
      logic [63:0] n, last;
      m = (ins[6:0] == 7'h2F) && (ins[31:28] == 4'b0011);
      st = ins[27];
      ill = 1'b0;
      sz = 2'd0; a = 1'b0; r = 1'b0; mk = 8'd0; ex = 4'd0;
      if (m) begin
         if (ins[14]) ill = 1'b1;
         if (!st && (!ins[26] || ins[24:20] != 5'd0)) ill = 1'b1;
         if (st && (!ins[25] || ins[11:7] != 5'd0)) ill = 1'b1;
      end
      v = m && !ill;
      if (v) begin
         sz = ins[13:12];
         n  = 64'd1 << sz;
         a  = st ? ins[26] : 1'b1;
         r  = st ? 1'b1 : ins[25];
         mk = 8'((16'd1 << n) - 16'd1);
         if ((ad % n) != 64'd0) begin
            last = ad + n - 64'd1;
            if ((ad >> TB_GL) != (last >> TB_GL))
               ex = st ? (ne ? 4'd7 : 4'd6) : (ne ? 4'd5 : 4'd4);
         end
      end
      return {m, v, ill, m & st, sz, a, r, mk, ex};
   endfunction

   function automatic logic [19:0] outs();
      return {o_match, o_valid, o_illegal, o_is_store, o_size, o_acq, o_rel, o_mask, o_exc};
   endfunction

   task automatic chk(input string tag, input string fld, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, fld, act, exp);
      end
   endtask

   task automatic cmp_all(input string tag, input logic [19:0] g, input logic [19:0] e);
      chk({tag, "/R1"},  "match",   8'(g[19]),    8'(e[19]));
      chk({tag, "/R11"}, "valid",   8'(g[18]),    8'(e[18]));
      chk({tag, "/R2/R3/R4"}, "illegal", 8'(g[17]), 8'(e[17]));
      chk({tag, "/R1"},  "store",   8'(g[16]),    8'(e[16]));
      chk({tag, "/R4"},  "size",    8'(g[15:14]), 8'(e[15:14]));
      chk({tag, "/R5"},  "acq",     8'(g[13]),    8'(e[13]));
      chk({tag, "/R5"},  "rel",     8'(g[12]),    8'(e[12]));
      chk({tag, "/R6"},  "mask",    g[11:4],      e[11:4]);
      chk({tag, "/R7/R8/R9/R10"}, "exc", 8'(g[3:0]), 8'(e[3:0]));
   endtask

   task automatic apply(input logic [31:0] ins, input logic [63:0] ad, input logic ne, input string tag);
      logic [19:0] e;
      @(negedge clk);
      i_instr = ins; i_addr = ad; i_no_emul = ne;
      e = model(ins, ad, ne);
      @(posedge clk);
      #1;
      cmp_all(tag, outs(), e);
   endtask

   localparam logic [6:0] AMO = 7'h2F;
   localparam logic [4:0] LDA = 5'b00110;
   localparam logic [4:0] STR = 5'b00111;

   initial begin
      logic [31:0] ins;
      logic [63:0] ad;
      logic [4:0]  f5;
      logic [6:0]  opc;
      logic [2:0]  f3;
      int          sel;
      void'($urandom(32'd20240611));

      rst_n = 1'b0;
      i_instr = enc(LDA, 1'b1, 1'b0, 5'd0, 5'd1, 3'b010, 5'd2, AMO);
      i_addr = 64'h1000;
      i_no_emul = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      cmp_all("R12 reset", outs(), 20'd0);
      @(negedge clk);
      rst_n = 1'b1;
      i_instr = enc(STR, 1'b0, 1'b1, 5'd3, 5'd1, 3'b011, 5'd0, AMO);
      #1;
      cmp_all("R12 before edge", outs(), 20'd0);
      @(posedge clk);
      #1;
      cmp_all("R12 after edge", outs(), model(i_instr, i_addr, i_no_emul));

      // R1 recognition
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h2000, 1'b0, "R1 lw.aq");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b000, 5'd0, AMO), 64'h2003, 1'b0, "R1 sb.rl");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, 7'h03), 64'h2000, 1'b0, "R1 other opcode");
      apply(enc(5'b00010, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h2000, 1'b0, "R1 other funct5");
      // R2 load reserved
      apply(enc(LDA, 1'b0, 1'b1, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h2000, 1'b0, "R2 load aq=0");
      apply(enc(LDA, 1'b1, 1'b0, 5'd5, 5'd4, 3'b010, 5'd7, AMO), 64'h2000, 1'b0, "R2 load rs2");
      // R3 store reserved
      apply(enc(STR, 1'b1, 1'b0, 5'd9, 5'd4, 3'b010, 5'd0, AMO), 64'h2000, 1'b0, "R3 store rl=0");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b010, 5'd3, AMO), 64'h2000, 1'b0, "R3 store rd");
      // R4 sizes
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b100, 5'd7, AMO), 64'h2000, 1'b0, "R4 funct3 100");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b111, 5'd7, AMO), 64'h2000, 1'b0, "R4 funct3 111");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b011, 5'd0, AMO), 64'h2008, 1'b0, "R4 R6 sd.rl");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b001, 5'd7, AMO), 64'h2002, 1'b0, "R4 R6 lh.aq");
      // R5 ordering
      apply(enc(LDA, 1'b1, 1'b1, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h2000, 1'b0, "R5 lw.aqrl");
      apply(enc(STR, 1'b1, 1'b1, 5'd9, 5'd4, 3'b010, 5'd0, AMO), 64'h2000, 1'b0, "R5 sw.aqrl");
      // R7..R10 alignment
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b000, 5'd7, AMO), 64'h200F, 1'b1, "R7 byte any");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h1002, 1'b0, "R10 word in granule");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b011, 5'd7, AMO), 64'h1004, 1'b1, "R10 dword in granule");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h100E, 1'b0, "R8 load cross");
      apply(enc(LDA, 1'b1, 1'b0, 5'd0, 5'd4, 3'b010, 5'd7, AMO), 64'h100E, 1'b1, "R9 load cross");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b011, 5'd0, AMO), 64'h100C, 1'b0, "R8 store cross");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b011, 5'd0, AMO), 64'h100C, 1'b1, "R9 store cross");
      apply(enc(STR, 1'b0, 1'b1, 5'd9, 5'd4, 3'b001, 5'd0, AMO), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R8 wrap");
      apply(enc(LDA, 1'b1, 1'b0, 5'd5, 5'd4, 3'b010, 5'd7, AMO), 64'h100E, 1'b1, "R11 illegal no exc");

      for (int k = 0; k < 4000; k++) begin
         opc = ($urandom % 8 == 0) ? 7'($urandom) : AMO;
         sel = int'($urandom % 8);
         if (sel < 3)       f5 = LDA;
         else if (sel < 6)  f5 = STR;
         else if (sel == 6) f5 = 5'($urandom);
         else               f5 = 5'b00010;
         f3 = ($urandom % 5 == 0) ? 3'($urandom) : {1'b0, 2'($urandom)};
         ins = enc(f5, 1'($urandom), 1'($urandom),
                   ($urandom % 4 == 0) ? 5'($urandom) : 5'd0, 5'($urandom), f3,
                   ($urandom % 4 == 0) ? 5'($urandom) : 5'd0, opc);
         ad = {$urandom, $urandom};
         apply(ins, ad, 1'($urandom), "random R1..R11");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule